// File: doc/BRIEF.md
# Register Rename Unit with Committed-State Recovery

This unit renames one instruction per cycle. Each instruction names two source registers and one destination register from a file of 32 architectural registers. The unit translates these names into tags for a pool of 64 physical registers. The source tags come from a live mapping table. The destination gets a fresh tag from a free pool, and the tag that the destination used to map to is returned alongside it. The reorder logic keeps that replaced tag and sends it back when the instruction commits, at which point the tag re-enters the free pool.

A second copy of the table, the committed copy, changes only at commit. It always describes the architectural state. When a trap or a mispredicted branch flushes the pipeline, the live table is overwritten by the committed copy in one cycle. In the same cycle the free pool is rebuilt to hold every physical register that the restored table does not reference.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register i maps to physical tag i for every i, and the stall output is low.
- R2: Source tags are read from the live table in the same cycle as the request. A destination renamed in one cycle is seen by source lookups from the next cycle onward.
- R3: An accepted rename with a non-zero destination receives the lowest-numbered free physical tag on the new-tag output. The replaced-tag output carries the tag that the destination mapped to before the rename.
- R4: Register 0 is never renamed. A source index of 0 always reads tag 0. A destination of 0 shows 0 on both the new and replaced tag outputs and uses no free tag.
- R5: When no tag is free, the stall output is high and a rename request changes no mapping.
- R6: A commit returns its replaced tag to the free pool, and the pool can hand that tag out again from the next cycle.
- R7: A commit writes its destination's new tag into the committed copy. A flush loads the whole live table from the committed copy, including a commit made in the same cycle.
- R8: On a flush, the free pool becomes exactly the set of physical tags that the restored table does not reference.
- R9: A rename request made in the same cycle as a flush is discarded.
- R10: When an instruction names the same register as a source and as its destination, the source gets the mapping from before the rename.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ren_valid_i | input | 1 | Rename request for this cycle |
| rs1_i | input | 5 | First source architectural index |
| rs2_i | input | 5 | Second source architectural index |
| rd_i | input | 5 | Destination architectural index, 0 for none |
| ps1_o | output | 6 | Physical tag of the first source |
| ps2_o | output | 6 | Physical tag of the second source |
| pd_o | output | 6 | Newly allocated destination tag |
| pd_old_o | output | 6 | Tag the destination replaced |
| stall_o | output | 1 | Free pool empty, rename held |
| commit_valid_i | input | 1 | An instruction commits this cycle |
| commit_rd_i | input | 5 | Destination index of the committing instruction |
| commit_new_i | input | 6 | Tag the committing destination now holds |
| commit_old_i | input | 6 | Replaced tag to free |
| flush_i | input | 1 | Restore the live table from committed state |

## Verification
The bench first uses up all 32 initially free tags and then checks that a stalled request leaves its register's mapping unchanged. A design that ignored the stall would silently remap that register. It then frees tags through commit and checks that the lowest freed tag is handed out next, which shows whether a release was lost. A flush is applied together with a commit and a discarded rename. A restore that missed the same-cycle commit, or that let the rename through, would show a wrong source tag afterwards. The sequence of tags allocated after the flush exposes a pool rebuild that leaked or double-counted a register. An instruction whose source is also its destination checks that the source reads the mapping from before the rename.

// File: rtl/rename_pkg.sv
package rename_pkg;
    localparam int ARCH_REGS = 32;
    localparam int PHYS_REGS = 64;
    localparam int ATAG_W    = $clog2(ARCH_REGS);
    localparam int PTAG_W    = $clog2(PHYS_REGS);

    typedef logic [ATAG_W-1:0]           atag_t;
    typedef logic [PTAG_W-1:0]           ptag_t;
    typedef ptag_t [ARCH_REGS-1:0]       map_t;
    typedef logic [PHYS_REGS-1:0]        fmask_t;

    function automatic map_t identity_map();
        map_t m;
        for (int i = 0; i < ARCH_REGS; i++) m[i] = ptag_t'(i);
        return m;
    endfunction

    function automatic fmask_t initial_free();
        fmask_t f;
        for (int i = 0; i < PHYS_REGS; i++) f[i] = (i >= ARCH_REGS);
        return f;
    endfunction
endpackage

// File: rtl/rename_maptable.sv
module rename_maptable
    import rename_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  atag_t rs1_i,
    input  atag_t rs2_i,
    input  atag_t rd_i,
    output ptag_t ps1_o,
    output ptag_t ps2_o,
    output ptag_t pold_o,
    input  logic  wr_en_i,
    input  ptag_t wr_tag_i,
    input  logic  cm_en_i,
    input  atag_t cm_rd_i,
    input  ptag_t cm_tag_i,
    input  logic  flush_i,
    output map_t  restore_o
);
    typedef struct packed {
        map_t live;
        map_t backup;
    } mt_state_t;

    mt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cm_en_i && cm_rd_i != '0) st_d.backup[cm_rd_i] = cm_tag_i;
        if (flush_i) begin
            st_d.live = st_d.backup;
        end else if (wr_en_i && rd_i != '0) begin
            st_d.live[rd_i] = wr_tag_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.live   <= identity_map();
            st_q.backup <= identity_map();
        end else begin
            st_q <= st_d;
        end
    end

    assign ps1_o     = st_q.live[rs1_i];
    assign ps2_o     = st_q.live[rs2_i];
    assign pold_o    = st_q.live[rd_i];
    assign restore_o = st_d.backup;
endmodule

// File: rtl/rename_freelist.sv
module rename_freelist
    import rename_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  alloc_i,
    input  logic  release_en_i,
    input  ptag_t release_tag_i,
    input  logic  flush_i,
    input  map_t  restore_i,
    output ptag_t free_tag_o,
    output logic  empty_o
);
    typedef struct packed {
        fmask_t avail;
    } fl_state_t;

    fl_state_t st_d, st_q;
    ptag_t     pick;
    fmask_t    used;

    always_comb begin
        pick = '0;
        for (int p = PHYS_REGS - 1; p >= 0; p--) begin
            if (st_q.avail[p]) pick = ptag_t'(p);
        end
    end

    always_comb begin
        used = '0;
        for (int p = 0; p < PHYS_REGS; p++) begin
            for (int a = 0; a < ARCH_REGS; a++) begin
                if (restore_i[a] == ptag_t'(p)) used[p] = 1'b1;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d.avail = ~used;
        end else begin
            if (alloc_i) st_d.avail[pick] = 1'b0;
            if (release_en_i && release_tag_i != '0) st_d.avail[release_tag_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.avail <= initial_free();
        else        st_q <= st_d;
    end

    assign free_tag_o = pick;
    assign empty_o    = (st_q.avail == '0);
endmodule

// File: rtl/reg_rename.sv
module reg_rename
    import rename_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ren_valid_i,
    input  logic [4:0]  rs1_i,
    input  logic [4:0]  rs2_i,
    input  logic [4:0]  rd_i,
    output logic [5:0]  ps1_o,
    output logic [5:0]  ps2_o,
    output logic [5:0]  pd_o,
    output logic [5:0]  pd_old_o,
    output logic        stall_o,
    input  logic        commit_valid_i,
    input  logic [4:0]  commit_rd_i,
    input  logic [5:0]  commit_new_i,
    input  logic [5:0]  commit_old_i,
    input  logic        flush_i
);
    ptag_t free_tag, old_tag;
    map_t  restore_map;
    logic  empty, has_dest, accept;

    assign has_dest = (rd_i != '0);
    assign accept   = ren_valid_i && !empty && !flush_i && has_dest;

    rename_maptable u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .rs1_i     (rs1_i),
        .rs2_i     (rs2_i),
        .rd_i      (rd_i),
        .ps1_o     (ps1_o),
        .ps2_o     (ps2_o),
        .pold_o    (old_tag),
        .wr_en_i   (accept),
        .wr_tag_i  (free_tag),
        .cm_en_i   (commit_valid_i),
        .cm_rd_i   (commit_rd_i),
        .cm_tag_i  (commit_new_i),
        .flush_i   (flush_i),
        .restore_o (restore_map)
    );

    rename_freelist u_free (
        .clk           (clk),
        .rst_n         (rst_n),
        .alloc_i       (accept),
        .release_en_i  (commit_valid_i),
        .release_tag_i (commit_old_i),
        .flush_i       (flush_i),
        .restore_i     (restore_map),
        .free_tag_o    (free_tag),
        .empty_o       (empty)
    );

    assign pd_o     = has_dest ? free_tag : '0;
    assign pd_old_o = has_dest ? old_tag  : '0;
    assign stall_o  = empty;
endmodule

// File: rtl/reg_rename_checker.sv
module reg_rename_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ren_valid_i,
    input logic [4:0] rs1_i,
    input logic [4:0] rd_i,
    input logic       flush_i,
    input logic       commit_valid_i,
    input logic [5:0] ps1_o,
    input logic [5:0] pd_o,
    input logic [5:0] pd_old_o,
    input logic       stall_o
);
    logic took;
    assign took = ren_valid_i && !stall_o && !flush_i && (rd_i != 5'd0);

    assert_x0_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rs1_i == 5'd0) |-> (ps1_o == 6'd0));

    assert_fresh_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        took |-> (pd_o != 6'd0 && pd_o != pd_old_o));

    assert_new_map_seen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        took |=> (rs1_i != $past(rd_i) || ps1_o == $past(pd_o)));

    assert_stall_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && !commit_valid_i && !flush_i) |=> stall_o);

    assert_flush_refills_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !stall_o);
endmodule

bind reg_rename reg_rename_checker u_chk (.*);

// File: tb/reg_rename_bench.sv
module reg_rename_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ren_valid_i = 1'b0;
    logic [4:0] rs1_i = '0, rs2_i = '0, rd_i = '0;
    logic [5:0] ps1_o, ps2_o, pd_o, pd_old_o;
    logic       stall_o;
    logic       commit_valid_i = 1'b0;
    logic [4:0] commit_rd_i = '0;
    logic [5:0] commit_new_i = '0, commit_old_i = '0;
    logic       flush_i = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    reg_rename u_reg_rename (.*);

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        ren_valid_i    = 1'b0;
        commit_valid_i = 1'b0;
        flush_i        = 1'b0;
    endtask

    task automatic lookup(input logic [4:0] a, output int tag);
        rs1_i = a;
        #1 tag = int'(ps1_o);
    endtask

    task automatic rename(input logic [4:0] d, input logic [4:0] s1, input logic [4:0] s2);
        ren_valid_i = 1'b1;
        rd_i = d; rs1_i = s1; rs2_i = s2;
        #1;
    endtask

    task automatic t_reset();
        int t;
        check("R1 stall after reset", int'(stall_o), 0);
        for (int i = 0; i < 32; i++) begin
            lookup(5'(i), t);
            check("R1 identity map", t, i);
        end
    endtask

    task automatic t_alloc();
        int t;
        rename(5'd5, 5'd5, 5'd3);
        check("R10 source same as dest", int'(ps1_o), 5);
        check("R2 second source", int'(ps2_o), 3);
        check("R3 new tag", int'(pd_o), 32);
        check("R3 replaced tag", int'(pd_old_o), 5);
        step();
        lookup(5'd5, t);
        check("R2 new mapping visible", t, 32);
        rename(5'd5, 5'd1, 5'd2);
        check("R3 second new tag", int'(pd_o), 33);
        check("R3 second replaced tag", int'(pd_old_o), 32);
        step();
    endtask

    task automatic t_x0();
        rename(5'd0, 5'd0, 5'd0);
        check("R4 x0 new tag", int'(pd_o), 0);
        check("R4 x0 replaced tag", int'(pd_old_o), 0);
        check("R4 x0 source", int'(ps1_o), 0);
        step();
        rename(5'd7, 5'd0, 5'd0);
        check("R4 no tag consumed", int'(pd_o), 34);
        step();
    endtask

    task automatic t_stall();
        int t;
        for (int k = 35; k < 64; k++) begin
            rename(5'd8, 5'd0, 5'd0);
            check("R3 sequential tag", int'(pd_o), k);
            step();
        end
        #1 check("R5 stall when empty", int'(stall_o), 1);
        rename(5'd9, 5'd0, 5'd0);
        step();
        lookup(5'd9, t);
        check("R5 stalled rename kept map", t, 9);
    endtask

    task automatic t_commit();
        commit_valid_i = 1'b1;
        commit_rd_i = 5'd5; commit_new_i = 6'd32; commit_old_i = 6'd5;
        step();
        #1 check("R6 stall cleared by commit", int'(stall_o), 0);
        rename(5'd10, 5'd0, 5'd0);
        check("R6 freed tag reused", int'(pd_o), 5);
        commit_valid_i = 1'b1;
        commit_rd_i = 5'd5; commit_new_i = 6'd33; commit_old_i = 6'd32;
        step();
    endtask

    task automatic t_flush();
        int t;
        flush_i = 1'b1;
        commit_valid_i = 1'b1;
        commit_rd_i = 5'd7; commit_new_i = 6'd34; commit_old_i = 6'd7;
        rename(5'd11, 5'd0, 5'd0);
        step();
        lookup(5'd5, t);  check("R7 restored committed map", t, 33);
        lookup(5'd7, t);  check("R7 same-cycle commit restored", t, 34);
        lookup(5'd8, t);  check("R7 uncommitted rename undone", t, 8);
        lookup(5'd10, t); check("R7 uncommitted rename undone", t, 10);
        lookup(5'd11, t); check("R9 rename during flush dropped", t, 11);
        check("R8 not stalled after flush", int'(stall_o), 0);
        rename(5'd12, 5'd0, 5'd0); check("R8 first free after flush", int'(pd_o), 5);  step();
        rename(5'd13, 5'd0, 5'd0); check("R8 second free after flush", int'(pd_o), 7); step();
        rename(5'd14, 5'd0, 5'd0); check("R8 third free after flush", int'(pd_o), 32); step();
        rename(5'd15, 5'd0, 5'd0); check("R8 fourth free after flush", int'(pd_o), 35); step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_alloc();
        t_x0();
        t_stall();
        t_commit();
        t_flush();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule